// File: doc/BRIEF.md
# Multichannel ADC Scan Controller

This block is the digital control and register front-end for a four-channel, 10-bit successive-approximation converter. Software sets it up through a byte-wide register bus. It sets the conversion mode, the trigger source, the range of channels to scan and the sampling time. The block then runs the analog converter through a sample/start/done handshake, one channel at a time. It keeps the latest result and reports progress through two status flags.

A scan covers every channel from a start channel up to an end channel, in ascending order. The scan can run once (normal mode) or repeat without pause (continuous mode). It begins on one of four trigger sources: a software write, a pulse from an 8-bit timer, a pulse from a 16-bit timer, or a falling edge on an external active-low pin. A completion flag marks an unread result and is also driven to a port for interrupt logic. An overwrite error flag records that an unread result was replaced by a newer one.

Top module: `adcScanTop`

## Requirements
- R1: After reset, registers 0 to 4 read 0x00 and register 5 reads 0x03. Register bits that hold no field always read 0. In register 3, bits 7 and 3 read 0. In register 5, bits 7:2 read 0.
- R2: The last result is read in two bytes. Address 0 returns result bits 7:0. Address 1 returns result bits 9:8 in bit positions 1:0, with bits 7:2 reading 0.
- R3: Register 2 bits 4:3 choose the trigger source: 00 software write, 01 a 16-bit timer pulse (`tmr16Trig`), 10 an 8-bit timer pulse (`tmr8Trig`), 11 a falling edge on `extTrigN`. Pulses from sources that are not selected start nothing.
- R4: Register 2 bit 0 is the enable bit and bit 1 is the run bit. Writing register 2 with both bits set starts a scan at once when the trigger field in that same write is 00. For any other trigger field, the same write arms the block to wait for its trigger. Bit 1 reads 1 while the block is armed or scanning.
- R5: In normal mode (register 2 bit 2 = 0), a scan converts each channel from the start channel (register 3 bits 2:0) to the end channel (register 3 bits 6:4) once, in ascending order. The run bit then reads 0. Channels AD0 to AD3 are encoded 000 to 011.
- R6: In continuous mode (register 2 bit 2 = 1), the scan restarts at the start channel after the end channel. This repeats until software writes register 2 with bit 1 = 0, which stops the block and clears the run bit.
- R7: When the start channel is greater than the end channel, a scan converts only the start channel.
- R8: Register 4 bits 4:2 read the channel being converted, or the last channel converted.
- R9: While the enable bit is 0, a write that sets only the run bit is ignored, and no sampling or conversion takes place. Writing 0 to the enable bit stops a running scan.
- R10: Register 4 bit 0 (the completion flag, also on the `adcDone` port) is set when a result is latched. It is cleared by a read of address 0 or address 1.
- R11: Register 4 bit 1 (the overwrite flag) is set when a result is latched while the completion flag is still set. The new result replaces the old one. Only a write of 0 to that bit clears it; a write of 1 has no effect.
- R12: For each channel, `anaSample` stays high for a number of `convTick` ticks set by register 5 bits 1:0: 11 gives 9, 10 gives 7, 01 gives 5 and 00 gives 3. It is followed by a one-cycle `anaStart` pulse.
- R13: A trigger that arrives while a scan is running does not start another scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (read side effects) |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| extTrigN | input | 1 | External trigger pin, active low, falling edge |
| tmr8Trig | input | 1 | 8-bit timer trigger pulse |
| tmr16Trig | input | 1 | 16-bit timer trigger pulse |
| convTick | input | 1 | Conversion clock enable for sampling time |
| anaSample | output | 1 | Sampling window to the analog converter |
| anaStart | output | 1 | Start-conversion pulse |
| anaChan | output | 2 | Channel selected for the analog converter |
| anaResult | input | 10 | Result from the analog converter |
| anaDone | input | 1 | Result-valid strobe from the analog converter |
| adcDone | output | 1 | Completion flag |

## Verification
On every cycle, the assertions check that the start pulse lasts one cycle and always follows a sampling window. They also check that a disabled block stays quiet, and that each rise of the completion or overwrite flag comes from a result latch, with the completion flag already set for an overwrite. Other behaviours can only be shown by the bench's scenarios. These are the sampling length for each code, the ascending channel order and the reversed-range case, and the trigger-source selection with its ignored pulses. The bench scenarios also cover read-to-clear and write-zero-to-clear of the flags, the continuous repeat with its stop, and triggers ignored mid-scan.

// File: rtl/adcScanPkg.sv
package adcScanPkg;

  localparam int ADR_RES_LO = 0;
  localparam int ADR_RES_HI = 1;
  localparam int ADR_CTRL   = 2;
  localparam int ADR_RANGE  = 3;
  localparam int ADR_STAT   = 4;
  localparam int ADR_SAMP   = 5;

  localparam logic [1:0] TRIG_SW    = 2'b00;
  localparam logic [1:0] TRIG_TMR16 = 2'b01;
  localparam logic [1:0] TRIG_TMR8  = 2'b10;
  localparam logic [1:0] TRIG_EXT   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_SAMPLE, ST_CONV, ST_WAIT
  } scanStateT;

  // Configuration held in the datapath, consumed by the control
  typedef struct packed {
    logic       en;
    logic       contMode;
    logic [1:0] trigSel;
    logic [2:0] startCh;
    logic [2:0] endCh;
    logic [1:0] sampleSel;
  } cfgT;

  // Software requests decoded from a control-register write
  typedef struct packed {
    logic arm;
    logic swTrig;
    logic stop;
  } ctlReqT;

  // Strobes from the control back to the datapath
  typedef struct packed {
    logic       latch;
    logic       busy;
    logic [2:0] chan;
  } ctlStbT;

endpackage

// File: rtl/adcScanData.sv
module adcScanData
  import adcScanPkg::*;
#(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  ctlStbT            stb,
  input  logic [RES_W-1:0]  anaResult,
  output cfgT               cfg,
  output ctlReqT            req,
  output logic              doneFlag,
  output logic              ovrFlag
);

  localparam int HI_W = RES_W - 8;

  logic [RES_W-1:0] resReg;
  logic             ctrlWr, rangeWr, statWr, sampWr, resRead;
  logic [7:0]       resHiByte;

  assign ctrlWr  = busWr && (busAddr == ADDR_W'(ADR_CTRL));
  assign rangeWr = busWr && (busAddr == ADDR_W'(ADR_RANGE));
  assign statWr  = busWr && (busAddr == ADDR_W'(ADR_STAT));
  assign sampWr  = busWr && (busAddr == ADDR_W'(ADR_SAMP));
  assign resRead = busRd && ((busAddr == ADDR_W'(ADR_RES_LO)) ||
                             (busAddr == ADDR_W'(ADR_RES_HI)));

  // Requests take enable and trigger from the write data itself
  always_comb begin
    req.arm    = ctrlWr && busWdata[1] && busWdata[0];
    req.swTrig = req.arm && (busWdata[4:3] == TRIG_SW);
    req.stop   = ctrlWr && !(busWdata[1] && busWdata[0]);
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg           <= '0;
      cfg.sampleSel <= 2'b11;
    end else begin
      if (ctrlWr) begin
        cfg.en       <= busWdata[0];
        cfg.contMode <= busWdata[2];
        cfg.trigSel  <= busWdata[4:3];
      end
      if (rangeWr) begin
        cfg.startCh <= busWdata[2:0];
        cfg.endCh   <= busWdata[6:4];
      end
      if (sampWr) cfg.sampleSel <= busWdata[1:0];
    end
  end

  // Result storage and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg   <= '0;
      doneFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else begin
      if (stb.latch) begin
        resReg   <= anaResult;
        doneFlag <= 1'b1;
      end else if (resRead) begin
        doneFlag <= 1'b0;
      end
      if (stb.latch && doneFlag && !resRead) ovrFlag <= 1'b1;
      else if (statWr && !busWdata[1])      ovrFlag <= 1'b0;
    end
  end

  generate
    if (HI_W > 0) begin : g_hiByte
      assign resHiByte = 8'(resReg[RES_W-1:8]);
    end else begin : g_noHiByte
      assign resHiByte = 8'h00;
    end
  endgenerate

  always_comb begin
    busRdata = 8'h00;
    case (busAddr)
      ADDR_W'(ADR_RES_LO): busRdata = resReg[7:0];
      ADDR_W'(ADR_RES_HI): busRdata = resHiByte;
      ADDR_W'(ADR_CTRL):   busRdata = {3'b000, cfg.trigSel, cfg.contMode, stb.busy, cfg.en};
      ADDR_W'(ADR_RANGE):  busRdata = {1'b0, cfg.endCh, 1'b0, cfg.startCh};
      ADDR_W'(ADR_STAT):   busRdata = {3'b000, stb.chan, ovrFlag, doneFlag};
      ADDR_W'(ADR_SAMP):   busRdata = {6'b000000, cfg.sampleSel};
      default:             busRdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/adcScanCtrl.sv
module adcScanCtrl
  import adcScanPkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  cfgT    cfg,
  input  ctlReqT req,
  input  logic   extTrigN,
  input  logic   tmr8Trig,
  input  logic   tmr16Trig,
  input  logic   convTick,
  input  logic   anaDone,
  output ctlStbT stb,
  output logic   anaSample,
  output logic   anaStart
);

  scanStateT        state, stateNxt;
  logic [1:0]       chan, chanNxt;
  logic [CNT_W-1:0] cnt, cntNxt, sampleLast;
  logic [SYNC_N:0]  extSync;
  logic             extFall, hwTrig, lastCh;

  // Pin synchronizer plus one stage for falling-edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '1;
    else       extSync <= {extSync[SYNC_N-1:0], extTrigN};
  end
  assign extFall = extSync[SYNC_N] && !extSync[SYNC_N-1];

  always_comb begin
    case (cfg.trigSel)
      TRIG_TMR16: hwTrig = tmr16Trig;
      TRIG_TMR8:  hwTrig = tmr8Trig;
      TRIG_EXT:   hwTrig = extFall;
      default:    hwTrig = 1'b0;
    endcase
  end

  // Ticks in window = 2*sel + 3, counter runs 0..last
  assign sampleLast = CNT_W'({cfg.sampleSel, 1'b0}) + CNT_W'(2);
  assign lastCh     = chan >= cfg.endCh[1:0];

  always_comb begin
    stateNxt = state;
    chanNxt  = chan;
    cntNxt   = cnt;
    if (req.stop || (!cfg.en && !req.arm)) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (req.arm) begin
          if (req.swTrig) begin
            stateNxt = ST_SAMPLE;
            chanNxt  = cfg.startCh[1:0];
            cntNxt   = '0;
          end else begin
            stateNxt = ST_ARMED;
          end
        end
        ST_ARMED: if (hwTrig) begin
          stateNxt = ST_SAMPLE;
          chanNxt  = cfg.startCh[1:0];
          cntNxt   = '0;
        end
        ST_SAMPLE: if (convTick) begin
          if (cnt == sampleLast) stateNxt = ST_CONV;
          else                   cntNxt   = cnt + CNT_W'(1);
        end
        ST_CONV: stateNxt = ST_WAIT;
        ST_WAIT: if (anaDone) begin
          cntNxt = '0;
          if (!lastCh) begin
            stateNxt = ST_SAMPLE;
            chanNxt  = chan + 2'd1;
          end else if (cfg.contMode) begin
            stateNxt = ST_SAMPLE;
            chanNxt  = cfg.startCh[1:0];
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chan  <= 2'd0;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      chan  <= chanNxt;
      cnt   <= cntNxt;
    end
  end

  assign anaSample = (state == ST_SAMPLE);
  assign anaStart  = (state == ST_CONV);

  always_comb begin
    stb.latch = (state == ST_WAIT) && anaDone;
    stb.busy  = (state != ST_IDLE);
    stb.chan  = {1'b0, chan};
  end

endmodule

// File: rtl/adcScanTop.sv
module adcScanTop
  import adcScanPkg::*;
#(
  parameter int RES_W  = 10,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              extTrigN,
  input  logic              tmr8Trig,
  input  logic              tmr16Trig,
  input  logic              convTick,
  output logic              anaSample,
  output logic              anaStart,
  output logic [1:0]        anaChan,
  input  logic [RES_W-1:0]  anaResult,
  input  logic              anaDone,
  output logic              adcDone
);

  cfgT    cfg;
  ctlReqT req;
  ctlStbT stb;
  logic   ovrFlag;

  adcScanData #(.RES_W(RES_W), .ADDR_W(ADDR_W)) data_i (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .stb(stb), .anaResult(anaResult),
    .cfg(cfg), .req(req),
    .doneFlag(adcDone), .ovrFlag(ovrFlag)
  );

  adcScanCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .req(req),
    .extTrigN(extTrigN), .tmr8Trig(tmr8Trig), .tmr16Trig(tmr16Trig),
    .convTick(convTick), .anaDone(anaDone),
    .stb(stb), .anaSample(anaSample), .anaStart(anaStart)
  );

  assign anaChan = stb.chan[1:0];

endmodule

// File: rtl/adcScanChk.sv
module adcScanChk (
  input logic clk,
  input logic rstN,
  input logic cfgEn,
  input logic arm,
  input logic anaSample,
  input logic anaStart,
  input logic latch,
  input logic adcDone,
  input logic ovrFlag
);

  // R12
  conv_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    anaStart |-> $past(anaSample));

  // R12
  single_start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anaStart |=> !anaStart);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && !arm) |=> (!anaSample && !anaStart));

  // R10
  done_from_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcDone) |-> $past(latch));

  // R11
  ovr_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> ($past(latch) && $past(adcDone)));

endmodule

bind adcScanTop adcScanChk chk_i (
  .clk(clk), .rstN(rstN),
  .cfgEn(cfg.en), .arm(req.arm),
  .anaSample(anaSample), .anaStart(anaStart),
  .latch(stb.latch), .adcDone(adcDone), .ovrFlag(ovrFlag)
);

// File: tb/adcScanTop_tb_top.sv
module adcScanTop_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic       extTrigN = 1'b1, tmr8Trig = 1'b0, tmr16Trig = 1'b0;
  logic       convTick = 1'b1;
  logic       anaSample, anaStart, anaDone = 1'b0, adcDone;
  logic [1:0] anaChan;
  logic [9:0] anaResult = '0;

  int checks = 0, errors = 0;
  int convCount = 0, runLen = 0, lastWidth = 0;
  int chanLog [256];

  always #5 clk = ~clk;

  adcScanTop dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extTrigN(extTrigN),
    .tmr8Trig(tmr8Trig), .tmr16Trig(tmr16Trig), .convTick(convTick),
    .anaSample(anaSample), .anaStart(anaStart), .anaChan(anaChan),
    .anaResult(anaResult), .anaDone(anaDone), .adcDone(adcDone)
  );

  function automatic logic [9:0] stubVal(input int ch);
    return {2'(ch), 8'(8'h3C + 8'(ch * 17))};
  endfunction

  // Behavioural converter: answers each start pulse after three cycles
  initial begin
    forever begin
      @(negedge clk);
      if (anaStart) begin
        automatic int ch = int'(anaChan);
        chanLog[convCount % 256] = ch;
        repeat (3) @(negedge clk);
        anaResult = stubVal(ch);
        anaDone = 1'b1;
        @(negedge clk);
        anaDone = 1'b0;
        convCount++;
      end
    end
  end

  // Sampling window width monitor (convTick held high)
  always @(negedge clk) begin
    if (anaSample) runLen++;
    else if (runLen != 0) begin
      lastWidth = runLen;
      runLen = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    busAddr = 3'(a); busWdata = 8'(d); busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input int a, output int d);
    @(negedge clk);
    busAddr = 3'(a); busRd = 1'b1;
    #1 d = int'(busRdata);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitIdle();
    int d;
    for (int i = 0; i < 2000; i++) begin
      busRead(2, d);
      if (d[1] == 1'b0) break;
    end
  endtask

  task automatic pulseSrc(input int src);
    @(negedge clk);
    if (src == 1) tmr16Trig = 1'b1;
    else if (src == 2) tmr8Trig = 1'b1;
    else if (src == 3) extTrigN = 1'b0;
    @(negedge clk);
    tmr16Trig = 1'b0; tmr8Trig = 1'b0;
    repeat (3) @(negedge clk);
    extTrigN = 1'b1;
  endtask

  typedef struct packed {
    logic [2:0] s;
    logic [2:0] e;
    logic [1:0] sel;
    logic [3:0] w;
    logic [1:0] last;
    logic       ovr;
    logic [2:0] n;
  } vecT;

  localparam vecT VECS [4] = '{
    '{3'd0, 3'd3, 2'd3, 4'd9, 2'd3, 1'b1, 3'd4},
    '{3'd1, 3'd1, 2'd2, 4'd7, 2'd1, 1'b0, 3'd1},
    '{3'd2, 3'd0, 2'd1, 4'd5, 2'd2, 1'b0, 3'd1},
    '{3'd0, 3'd1, 2'd0, 4'd3, 2'd1, 1'b1, 3'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R2 result bytes at reset
    busRead(0, d); chk("R2 reset resLo", d, 0);
    busRead(1, d); chk("R2 reset resHi", d, 0);
    busRead(2, d); chk("R1 reset ctrl", d, 0);
    busRead(3, d); chk("R1 reset range", d, 0);
    busRead(4, d); chk("R1 reset status", d, 0);
    busRead(5, d); chk("R1 reset sample", d, 3);
    chk("R10 reset adcDone", int'(adcDone), 0);
    busWrite(5, 8'hFF); busRead(5, d); chk("R1 sample unused bits", d, 8'h03);
    busWrite(3, 8'hFF); busRead(3, d); chk("R1 range unused bits", d, 8'h77);

    // Table of normal software-started scans
    foreach (VECS[i]) begin
      base = convCount;
      busWrite(3, {1'b0, VECS[i].e, 1'b0, VECS[i].s});
      busWrite(5, VECS[i].sel);
      busWrite(2, 8'h03);
      busRead(2, d); chk("R4 run bit during scan", d & 2, 2);
      waitIdle();
      repeat (2) @(negedge clk);
      chk("R5 R7 conversions per scan", convCount - base, int'(VECS[i].n));
      chk("R12 sampling window width", lastWidth, int'(VECS[i].w));
      if (i == 0) begin
        for (int k = 0; k < 4; k++)
          chk("R5 ascending channel order", chanLog[(base + k) % 256], k);
      end
      busRead(4, d);
      chk("R10 done flag set", d & 1, 1);
      chk("R11 overwrite flag", (d >> 1) & 1, int'(VECS[i].ovr));
      chk("R8 channel status", (d >> 2) & 7, int'(VECS[i].last));
      busRead(0, d); chk("R2 result low byte", d, int'(stubVal(int'(VECS[i].last)) & 10'hFF));
      busRead(1, d); chk("R2 result high byte", d, int'(VECS[i].last));
      busRead(4, d); chk("R10 done cleared by read", d & 1, 0);
      chk("R10 adcDone port cleared", int'(adcDone), 0);
      if (VECS[i].ovr) begin
        busWrite(4, 8'hFF); busRead(4, d); chk("R11 write one keeps flag", (d >> 1) & 1, 1);
      end
      busWrite(4, 8'h00); busRead(4, d); chk("R11 write zero clears", (d >> 1) & 1, 0);
    end

    // R9 disabled: run-only write ignored
    busWrite(5, 8'h03);
    busWrite(3, 8'h00);
    base = convCount;
    busWrite(2, 8'h02);
    busRead(2, d); chk("R9 run ignored while disabled", d, 0);
    repeat (30) @(negedge clk);
    chk("R9 no conversion while disabled", convCount - base, 0);

    // R9 clearing enable stops a scan
    busWrite(3, 8'h30);
    busWrite(2, 8'h03);
    repeat (5) @(negedge clk);
    busWrite(2, 8'h00);
    repeat (20) @(negedge clk);
    base = convCount;
    busRead(2, d); chk("R9 disable stops scan", d & 2, 0);
    repeat (40) @(negedge clk);
    chk("R9 no further conversions", convCount - base, 0);
    busRead(0, d);
    busWrite(4, 8'h00);

    // R3 R4 hardware triggers: 1=16-bit timer, 2=8-bit timer, 3=ext pin
    busWrite(3, 8'h11);
    for (int src = 1; src <= 3; src++) begin
      base = convCount;
      busWrite(2, (src << 3) | 3);
      repeat (20) @(negedge clk);
      busRead(2, d); chk("R4 armed run bit", d & 2, 2);
      chk("R3 waits for trigger", convCount - base, 0);
      for (int o = 1; o <= 3; o++) if (o != src) pulseSrc(o);
      repeat (20) @(negedge clk);
      chk("R3 other sources ignored", convCount - base, 0);
      pulseSrc(src);
      waitIdle();
      repeat (2) @(negedge clk);
      chk("R3 selected source starts scan", convCount - base, 1);
      busRead(0, d);
    end

    // R13 trigger during a running scan is ignored
    busWrite(3, 8'h10);
    base = convCount;
    busWrite(2, 8'h13);
    pulseSrc(2);
    repeat (4) @(negedge clk);
    pulseSrc(2);
    waitIdle();
    repeat (40) @(negedge clk);
    chk("R13 second trigger ignored", convCount - base, 2);
    busRead(2, d); chk("R13 idle after scan", d & 2, 0);
    busRead(0, d);
    busWrite(4, 8'h00);

    // R6 continuous mode on channel 2, then stop
    busWrite(3, 8'h22);
    base = convCount;
    busWrite(2, 8'h07);
    for (int t = 0; t < 2000 && convCount - base < 3; t++) @(negedge clk);
    busRead(2, d); chk("R6 still running in continuous", d & 2, 2);
    chk("R6 repeated conversions", int'(convCount - base >= 3), 1);
    busRead(4, d); chk("R8 status shows channel 2", (d >> 2) & 7, 2);
    busWrite(2, 8'h01);
    repeat (30) @(negedge clk);
    base = convCount;
    busRead(2, d); chk("R6 stop clears run", d & 2, 0);
    repeat (60) @(negedge clk);
    chk("R6 no conversions after stop", convCount - base, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule